// File: doc/BRIEF.md
# Measurement Power-Mode Controller

This block sequences a sigma-delta measurement path between an idle Stop state and four operating modes. A host asks for a mode through a two-bit request and a run level. The controller then flushes the decimation path for a fixed number of cycles before the new mode starts sampling. Two full-power modes keep the path sampling all the time. One of them runs at the high rate permanently. The other starts at the low rate and moves up to the high rate while the current comparator reports an above-threshold level. It drops back after a programmable run of calm samples.

Two low-power modes sample only on events. The timed standby mode fires a single-cycle sample enable after every programmed number of slow ticks. The wake-up standby mode samples only while the current comparator is above threshold, and each such event latches an interrupt that stays high until the host acknowledges it. Every mode change passes through Stop, so a new mode never inherits filter state from the previous one.

Top module: `meas_mode_ctrl`

## Requirements
- R1: After reset the controller is in Stop, with samp_en_o, rate_hi_o, low_pwr_o, flush_o and irq_o all low.
- R2: From any mode or from flushing, run_i low or a mode_req_i that differs from the active mode moves the controller to Stop on the next clock, where samp_en_o, flush_o, rate_hi_o and low_pwr_o are low.
- R3: From Stop with run_i high, flush_o is high for exactly FLUSH_CYC cycles with samp_en_o low, and then the requested mode starts.
- R4: The mode_req_i encoding is 0 = full power fixed, 1 = full power adaptive, 2 = standby timed, 3 = standby wake. In mode 0, samp_en_o and rate_hi_o are high and low_pwr_o is low.
- R5: In mode 1, samp_en_o is high and rate_hi_o starts low after entry. A cycle with samp_vld_i and cmp_above_i both high makes rate_hi_o high from the next cycle.
- R6: In mode 1 with rate_hi_o high, rate_hi_o goes low on the cycle after the Nth consecutive samp_vld_i sample with cmp_above_i low, where N is calm_lim_i (0 counts as 1). An above-threshold sample restarts the count.
- R7: In mode 2, low_pwr_o is high and rate_hi_o is low. samp_en_o is high for exactly one cycle, the cycle after every Kth slow_tick_i pulse counted from mode entry, where K is stby_ivl_i (0 counts as 1). Cycles without a tick do not count.
- R8: In mode 3, low_pwr_o is high. Every cycle with cmp_above_i high makes samp_en_o high on the next cycle and sets irq_o. cmp_above_i sets irq_o in no other mode.
- R9: irq_o stays high until a cycle with int_ack_i high, including across Stop. When the same cycle also carries a wake event, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Host run request; low forces Stop |
| mode_req_i | input | 2 | Requested mode (encoding in R4) |
| cmp_above_i | input | 1 | Current comparator flag, high above threshold |
| samp_vld_i | input | 1 | Strobe from the decimation path, one per output sample |
| slow_tick_i | input | 1 | Slow timebase tick for the standby timer |
| stby_ivl_i | input | TMR_W | Standby sample interval in slow ticks |
| calm_lim_i | input | CALM_W | Calm samples needed to leave the high rate |
| int_ack_i | input | 1 | Host interrupt acknowledge |
| samp_en_o | output | 1 | Sample enable to the decimation path |
| rate_hi_o | output | 1 | High sample rate select |
| low_pwr_o | output | 1 | Low-power mode indicator |
| flush_o | output | 1 | Decimation path flush |
| irq_o | output | 1 | Threshold wake-up interrupt |

## Verification
Several properties are checked on every cycle: flushing never overlaps sampling, a dropped run level idles the outputs on the next cycle, an above-threshold sample raises the rate in the adaptive mode, standby never selects the high rate, and the interrupt is set by a wake event and held until it is acknowledged. Other behaviours depend on counts and ordering, and only the bench scenarios show them: the exact flush length, the calm-count threshold together with its restart, and the tick-interval pulse spacing across a sweep of limits. The bench also covers interrupt persistence across Stop.

// File: rtl/meas_mode_pkg.sv
package meas_mode_pkg;

  typedef enum logic [2:0] {
    ST_STOP     = 3'd0,
    ST_FLUSH    = 3'd1,
    ST_NRM_FIX  = 3'd2,
    ST_NRM_ADP  = 3'd3,
    ST_SBY_TMR  = 3'd4,
    ST_SBY_WAKE = 3'd5
  } mm_state_e;

  localparam logic [1:0] REQ_NRM_FIX  = 2'd0;
  localparam logic [1:0] REQ_NRM_ADP  = 2'd1;
  localparam logic [1:0] REQ_SBY_TMR  = 2'd2;
  localparam logic [1:0] REQ_SBY_WAKE = 2'd3;

  function automatic mm_state_e req_to_state(logic [1:0] req);
    case (req)
      REQ_NRM_FIX: return ST_NRM_FIX;
      REQ_NRM_ADP: return ST_NRM_ADP;
      REQ_SBY_TMR: return ST_SBY_TMR;
      default:     return ST_SBY_WAKE;
    endcase
  endfunction

endpackage

// File: rtl/mm_seq.sv
module mm_seq
  import meas_mode_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic [1:0] req_i,
  output mm_state_e state_o
);
  localparam int FC_W = (FLUSH_CYC < 2) ? 1 : $clog2(FLUSH_CYC);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FLUSH_CYC - 1);

  mm_state_e      st_q, st_d;
  logic [1:0]     tgt_q, tgt_d;
  logic [FC_W-1:0] fcnt_q, fcnt_d;
  logic           hold;

  // mode stays only while run is held and request matches the latched target
  assign hold = run_i && (req_i == tgt_q);

  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    fcnt_d = fcnt_q;
    case (st_q)
      ST_STOP: begin
        if (run_i) begin
          st_d   = ST_FLUSH;
          tgt_d  = req_i;
          fcnt_d = FC_LAST;
        end
      end
      ST_FLUSH: begin
        if (!hold)             st_d = ST_STOP;
        else if (fcnt_q == '0) st_d = req_to_state(tgt_q);
        else                   fcnt_d = fcnt_q - 1'b1;
      end
      default: begin
        if (!hold) st_d = ST_STOP;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STOP;
      tgt_q  <= REQ_NRM_FIX;
      fcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/mm_rate_adapt.sv
module mm_rate_adapt #(
  parameter int CALM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic              above_i,
  input  logic [CALM_W-1:0] calm_lim_i,
  output logic              hi_o
);
  localparam int CW1 = CALM_W + 1;

  logic              hi_q;
  logic [CALM_W-1:0] calm_q;
  logic [CW1-1:0]    lim_ext, calm_nxt;

  assign lim_ext  = (calm_lim_i == '0) ? CW1'(1) : {1'b0, calm_lim_i};
  assign calm_nxt = {1'b0, calm_q} + CW1'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      calm_q <= '0;
    end else if (!en_i) begin
      hi_q   <= 1'b0;
      calm_q <= '0;
    end else if (vld_i) begin
      if (above_i) begin
        hi_q   <= 1'b1;
        calm_q <= '0;
      end else if (hi_q) begin
        if (calm_nxt >= lim_ext) begin
          hi_q   <= 1'b0;
          calm_q <= '0;
        end else begin
          calm_q <= calm_nxt[CALM_W-1:0];
        end
      end
    end
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/mm_stby_timer.sv
module mm_stby_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] ivl_i,
  output logic             pulse_o
);
  logic [TMR_W-1:0] cnt_q, last;
  logic             pulse_q;

  assign last = (ivl_i == '0) ? '0 : ivl_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q >= last) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/mm_wake_irq.sv
module mm_wake_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic above_i,
  input  logic ack_i,
  output logic wake_o,
  output logic irq_o
);
  logic wake_q, irq_q, ev;

  assign ev = en_i & above_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wake_q <= ev;
      irq_q  <= (irq_q & ~ack_i) | ev;  // set beats ack
    end
  end

  assign wake_o = wake_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/meas_mode_ctrl.sv
module meas_mode_ctrl
  import meas_mode_pkg::*;
#(
  parameter int FLUSH_CYC = 4,
  parameter int TMR_W     = 16,
  parameter int CALM_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [1:0]        mode_req_i,
  input  logic              cmp_above_i,
  input  logic              samp_vld_i,
  input  logic              slow_tick_i,
  input  logic [TMR_W-1:0]  stby_ivl_i,
  input  logic [CALM_W-1:0] calm_lim_i,
  input  logic              int_ack_i,
  output logic              samp_en_o,
  output logic              rate_hi_o,
  output logic              low_pwr_o,
  output logic              flush_o,
  output logic              irq_o
);
  mm_state_e st;
  logic      adp_hi, tmr_pulse, wake;

  mm_seq #(.FLUSH_CYC(FLUSH_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .req_i   (mode_req_i),
    .state_o (st)
  );

  mm_rate_adapt #(.CALM_W(CALM_W)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (st == ST_NRM_ADP),
    .vld_i      (samp_vld_i),
    .above_i    (cmp_above_i),
    .calm_lim_i (calm_lim_i),
    .hi_o       (adp_hi)
  );

  mm_stby_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (st == ST_SBY_TMR),
    .tick_i  (slow_tick_i),
    .ivl_i   (stby_ivl_i),
    .pulse_o (tmr_pulse)
  );

  mm_wake_irq u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (st == ST_SBY_WAKE),
    .above_i (cmp_above_i),
    .ack_i   (int_ack_i),
    .wake_o  (wake),
    .irq_o   (irq_o)
  );

  always_comb begin
    samp_en_o = 1'b0;
    rate_hi_o = 1'b0;
    low_pwr_o = 1'b0;
    flush_o   = 1'b0;
    case (st)
      ST_FLUSH:    flush_o = 1'b1;
      ST_NRM_FIX:  begin samp_en_o = 1'b1; rate_hi_o = 1'b1; end
      ST_NRM_ADP:  begin samp_en_o = 1'b1; rate_hi_o = adp_hi; end
      ST_SBY_TMR:  begin samp_en_o = tmr_pulse; low_pwr_o = 1'b1; end
      ST_SBY_WAKE: begin samp_en_o = wake; low_pwr_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/mm_chk.sv
module mm_chk
  import meas_mode_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      run_i,
  input logic [1:0] mode_req_i,
  input logic      cmp_above_i,
  input logic      samp_vld_i,
  input logic      int_ack_i,
  input logic      samp_en_o,
  input logic      rate_hi_o,
  input logic      low_pwr_o,
  input logic      flush_o,
  input logic      irq_o,
  input mm_state_e st_i
);
  AST_FLUSH_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !samp_en_o && !rate_hi_o && !low_pwr_o); // R3

  AST_RUN_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !samp_en_o && !flush_o && !rate_hi_o && !low_pwr_o); // R2

  AST_ADP_RATE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_NRM_ADP) && run_i && (mode_req_i == REQ_NRM_ADP) && samp_vld_i && cmp_above_i
      |=> rate_hi_o); // R5

  AST_STBY_LOW_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_pwr_o |-> !rate_hi_o && !flush_o); // R7

  AST_WAKE_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SBY_WAKE) && cmp_above_i |=> irq_o); // R8

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !int_ack_i |=> irq_o); // R9
endmodule

bind meas_mode_ctrl mm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .mode_req_i  (mode_req_i),
  .cmp_above_i (cmp_above_i),
  .samp_vld_i  (samp_vld_i),
  .int_ack_i   (int_ack_i),
  .samp_en_o   (samp_en_o),
  .rate_hi_o   (rate_hi_o),
  .low_pwr_o   (low_pwr_o),
  .flush_o     (flush_o),
  .irq_o       (irq_o),
  .st_i        (st)
);

// File: tb/tb_meas_mode_ctrl.sv
`timescale 1ns/1ps
module tb_meas_mode_ctrl;
  localparam int FC     = 4;
  localparam int TMR_W  = 16;
  localparam int CALM_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, cmp = 1'b0, vld = 1'b0, tick = 1'b0, ack = 1'b0;
  logic [1:0] req = 2'd0;
  logic [TMR_W-1:0] ivl = '0;
  logic [CALM_W-1:0] calm = '0;
  logic samp_en, rate_hi, low_pwr, flush, irq;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  meas_mode_ctrl #(.FLUSH_CYC(FC), .TMR_W(TMR_W), .CALM_W(CALM_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_req_i(req),
    .cmp_above_i(cmp), .samp_vld_i(vld), .slow_tick_i(tick),
    .stby_ivl_i(ivl), .calm_lim_i(calm), .int_ack_i(ack),
    .samp_en_o(samp_en), .rate_hi_o(rate_hi), .low_pwr_o(low_pwr),
    .flush_o(flush), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string tag, input logic s, input logic r,
                          input logic l, input logic f);
    chk({tag, " samp_en"}, samp_en, s);
    chk({tag, " rate_hi"}, rate_hi, r);
    chk({tag, " low_pwr"}, low_pwr, l);
    chk({tag, " flush"},   flush,   f);
  endtask

  task automatic go_stop();
    run = 1'b0;
    @(negedge clk);
    chk_outs("R2 stop", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // from Stop: check flush window then land in mode m
  task automatic enter(input logic [1:0] m);
    req = m; run = 1'b1;
    for (int i = 0; i < FC; i++) begin
      @(negedge clk);
      chk_outs("R3 flush", 1'b0, 1'b0, 1'b0, 1'b1);
    end
    @(negedge clk);
    chk("R3 flush end", flush, 1'b0);
  endtask

  task automatic sample(input logic above);
    vld = 1'b1; cmp = above;
    @(negedge clk);
    vld = 1'b0; cmp = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lim, k_ivl;
    @(negedge clk);
    chk_outs("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_outs("R1 idle", 1'b0, 1'b0, 1'b0, 1'b0);

    // R4 fixed full power
    enter(2'd0);
    chk_outs("R4 fixed", 1'b1, 1'b1, 1'b0, 1'b0);
    sample(1'b0);
    chk_outs("R4 fixed hold", 1'b1, 1'b1, 1'b0, 1'b0);
    // R2 mode change while running -> Stop then flush
    req = 2'd1;
    @(negedge clk);
    chk_outs("R2 req change", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 reflush", flush, 1'b1);
    // R2 abort during flush
    run = 1'b0;
    @(negedge clk);
    chk_outs("R2 flush abort", 1'b0, 1'b0, 1'b0, 1'b0);

    // R5/R6 sweep calm limits
    for (int c = 0; c <= 5; c++) begin
      calm = CALM_W'(c);
      lim = (c == 0) ? 1 : c;
      enter(2'd1);
      chk_outs("R5 adp entry", 1'b1, 1'b0, 1'b0, 1'b0);
      sample(1'b0);
      chk("R5 below stays low", rate_hi, 1'b0);
      sample(1'b1);
      chk("R5 rate up", rate_hi, 1'b1);
      for (int k = 1; k < lim; k++) begin
        sample(1'b0);
        chk("R6 partial calm", rate_hi, 1'b1);
      end
      sample(1'b1);
      chk("R6 restart", rate_hi, 1'b1);
      repeat (3) @(negedge clk);
      chk("R6 no vld no count", rate_hi, 1'b1);
      for (int k = 1; k <= lim; k++) begin
        sample(1'b0);
        chk("R6 calm count", rate_hi, (k < lim) ? 1'b1 : 1'b0);
      end
      go_stop();
    end

    // R7 sweep intervals
    for (int v = 0; v <= 4; v++) begin
      ivl = TMR_W'(v);
      k_ivl = (v == 0) ? 1 : v;
      enter(2'd2);
      chk_outs("R7 entry", 1'b0, 1'b0, 1'b1, 1'b0);
      cmp = 1'b1;
      @(negedge clk);
      cmp = 1'b0;
      chk("R8 no irq in timed", irq, 1'b0);
      for (int t = 1; t <= 3 * k_ivl; t++) begin
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R7 tick pulse", samp_en, (t % k_ivl == 0) ? 1'b1 : 1'b0);
        chk("R7 rate low", rate_hi, 1'b0);
        @(negedge clk);
        chk("R7 gap", samp_en, 1'b0);
      end
      go_stop();
    end

    // R8/R9 wake mode
    enter(2'd3);
    chk_outs("R8 entry", 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 irq idle", irq, 1'b0);
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    chk("R8 wake sample", samp_en, 1'b1);
    chk("R8 irq set", irq, 1'b1);
    @(negedge clk);
    chk("R8 sample ends", samp_en, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 irq held", irq, 1'b1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 irq cleared", irq, 1'b0);
    cmp = 1'b1; ack = 1'b1;
    @(negedge clk);
    cmp = 1'b0; ack = 1'b0;
    chk("R9 set wins", irq, 1'b1);
    go_stop();
    chk("R9 held across stop", irq, 1'b1);
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    chk("R8 no wake in stop", samp_en, 1'b0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 ack in stop", irq, 1'b0);
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    chk("R8 no irq in stop", irq, 1'b0);

    finish_run();
  end
endmodule